// File: doc/BRIEF.md
# Effective-Privilege Trigger Mode Filter

This block decides whether a load/store address-match trigger may fire for one memory access. The privilege filter and the breakpoint reentrancy guard both look at the privilege and virtualization state that the access is actually performed with, and not at the mode the hart happens to be executing in. As a result, a load or store that a hypervisor issues on behalf of a guest is checked against the guest's trigger enables. The same holds for an M-mode access that borrows a lower privilege through the modify-privilege status bit.

On every cycle where the access-valid strobe is high, the block takes the following inputs and resolves the effective mode from them:
- the current privilege and virtualization bit;
- the modify-privilege, make-executable-readable, previous-privilege and previous-virtualization status fields;
- the hypervisor previous-privilege bit;
- an access-kind code.

The block then selects one of the trigger's five per-mode enables. It combines that enable with the raw address hit, the exclusion rules and the reentrancy guard. The fire decision and the effective mode appear on registered outputs one cycle later. The address comparator, the trigger actions and the control registers sit outside this block.

Top module: `effpriv_trig_filter`

## Requirements
- R1: After reset, `fire` is 0 and `effMode` is 3'b011 (M-mode, not virtual).
- R2: `effMode` is coded as {virtual, priv[1:0]}, with priv coded U=0, S=1, M=3. For an ordinary access (accKind=0) with the modify-privilege bit clear, or with the hart not in M-mode, the effective mode is the current privilege and virtualization state, and the virtual bit is forced to 0 when the current privilege is M.
- R3: For hypervisor virtual-machine accesses (accKind 1 = load, 2 = store, 3 = execute-permission load), the effective mode is virtual S when `spvp`=1 and virtual U when `spvp`=0.
- R4: An access with accKind=3 never fires, whatever the enables are.
- R5: An access made while `mprv`=1 and `mxr`=1 never fires.
- R6: When the current privilege is M and `mprv`=1, an ordinary access takes its effective mode from `mpp`/`mpv`, and `mpv` is ignored when `mpp` is M.
- R7: When the effective mode is M and `mie`=0, firing is suppressed (reentrancy guard).
- R8: `fire` is the AND of `addrHit`, the enable selected by the effective mode, no exclusion and no suppression. The enable bits of `modeEn` are bit0=U, bit1=S, bit2=M, bit3=VU, bit4=VS, and privilege code 2 selects no enable.
- R9: `fire` and `effMode` show the result of a valid access in the cycle after `accValid`. `fire` is 0 in the cycle after a cycle without `accValid`.
- R10: `effMode` holds its value through cycles without `accValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| curPriv | input | 2 | Current privilege (U=0, S=1, M=3) |
| curVirt | input | 1 | Current virtualization bit |
| mprv | input | 1 | Modify-privilege status bit |
| mxr | input | 1 | Make-executable-readable status bit |
| mpp | input | 2 | Previous privilege for modify-privilege accesses |
| mpv | input | 1 | Previous virtualization for modify-privilege accesses |
| spvp | input | 1 | Hypervisor previous-privilege bit |
| mie | input | 1 | M-mode interrupt enable |
| accKind | input | 2 | 0 ordinary, 1 hyp load, 2 hyp store, 3 hyp exec-permission load |
| modeEn | input | 5 | Trigger enables {VS, VU, M, S, U} |
| addrHit | input | 1 | Raw address-match hit |
| fire | output | 1 | Qualified trigger fire, registered |
| effMode | output | 3 | Effective mode {virt, priv}, registered |

## Verification
The block has no size parameters, so the bench builds it as it stands. It sweeps every legal combination of current privilege, virtualization, the status fields, `spvp`, `mie` and access kind against all 32 patterns of `modeEn` with the address hit set. This covers every pairing of an effective mode with an enable bit, as well as each exclusion rule and the suppression rule. Separate passes cover the unset hit, idle cycles, and the reserved privilege code.

// File: rtl/effpriv_pkg.sv
package effpriv_pkg;
  localparam int PRIV_W  = 2;
  localparam int MODE_W  = PRIV_W + 1;
  localparam int NUM_EN  = 5;
  localparam int KIND_W  = 2;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  typedef enum logic [KIND_W-1:0] {
    KIND_PLAIN = 2'd0,
    KIND_HLOAD = 2'd1,
    KIND_HSTORE = 2'd2,
    KIND_HEXEC = 2'd3
  } accKind_e;

  typedef struct packed {
    logic capture;
    logic fireReq;
    logic [MODE_W-1:0] mode;
  } ctrlStrobe_t;
endpackage

// File: rtl/effpriv_ctrl.sv
module effpriv_ctrl
  import effpriv_pkg::*;
(
  input  logic              accValid,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              curVirt,
  input  logic              mprv,
  input  logic              mxr,
  input  logic [PRIV_W-1:0] mpp,
  input  logic              mpv,
  input  logic              spvp,
  input  logic              mie,
  input  logic [KIND_W-1:0] accKind,
  input  logic [NUM_EN-1:0] modeEn,
  input  logic              addrHit,
  output ctrlStrobe_t       strobe
);
  accKind_e kind;
  logic [PRIV_W-1:0] effPriv;
  logic effVirt;
  logic selEn;
  logic excluded;
  logic suppressed;

  assign kind = accKind_e'(accKind);

  always_comb begin
    if (kind != KIND_PLAIN) begin
      effPriv = spvp ? PRIV_S : PRIV_U;
      effVirt = 1'b1;
    end else if (mprv && curPriv == PRIV_M) begin
      effPriv = mpp;
      effVirt = (mpp == PRIV_M) ? 1'b0 : mpv;
    end else begin
      effPriv = curPriv;
      effVirt = (curPriv == PRIV_M) ? 1'b0 : curVirt;
    end
  end

  always_comb begin
    unique case ({effVirt, effPriv})
      {1'b0, PRIV_U}: selEn = modeEn[0];
      {1'b0, PRIV_S}: selEn = modeEn[1];
      {1'b0, PRIV_M}: selEn = modeEn[2];
      {1'b1, PRIV_U}: selEn = modeEn[3];
      {1'b1, PRIV_S}: selEn = modeEn[4];
      default:        selEn = 1'b0;
    endcase
  end

  assign excluded   = (kind == KIND_HEXEC) || (mprv && mxr);
  assign suppressed = (effPriv == PRIV_M) && !effVirt && !mie;

  assign strobe.capture = accValid;
  assign strobe.fireReq = accValid && addrHit && selEn && !excluded && !suppressed;
  assign strobe.mode    = {effVirt, effPriv};
endmodule

// File: rtl/effpriv_dpath.sv
module effpriv_dpath
  import effpriv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic              fire,
  output logic [MODE_W-1:0] effMode
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fire    <= 1'b0;
      effMode <= {1'b0, PRIV_M};
    end else begin
      fire <= strobe.fireReq;
      if (strobe.capture) effMode <= strobe.mode;
    end
  end
endmodule

// File: rtl/effpriv_trig_filter.sv
module effpriv_trig_filter
  import effpriv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              curVirt,
  input  logic              mprv,
  input  logic              mxr,
  input  logic [PRIV_W-1:0] mpp,
  input  logic              mpv,
  input  logic              spvp,
  input  logic              mie,
  input  logic [KIND_W-1:0] accKind,
  input  logic [NUM_EN-1:0] modeEn,
  input  logic              addrHit,
  output logic              fire,
  output logic [MODE_W-1:0] effMode
);
  ctrlStrobe_t strobe;

  effpriv_ctrl u_ctrl (
    .accValid(accValid), .curPriv(curPriv), .curVirt(curVirt),
    .mprv(mprv), .mxr(mxr), .mpp(mpp), .mpv(mpv), .spvp(spvp),
    .mie(mie), .accKind(accKind), .modeEn(modeEn), .addrHit(addrHit),
    .strobe(strobe)
  );

  effpriv_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fire(fire), .effMode(effMode)
  );
endmodule

// File: rtl/effpriv_trig_filter_chk.sv
module effpriv_trig_filter_chk
  import effpriv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [PRIV_W-1:0] curPriv,
  input logic              mprv,
  input logic              mxr,
  input logic              mie,
  input logic [KIND_W-1:0] accKind,
  input logic              addrHit,
  input logic              fire,
  input logic [MODE_W-1:0] effMode
);
  AST_HEXEC_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accKind == 2'd3 |=> !fire); // R4
  AST_MXR_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    accValid && mprv && mxr |=> !fire); // R5
  AST_HYP_VIRTUAL: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accKind != 2'd0 |=> effMode[2] && effMode[1:0] != PRIV_M); // R3
  AST_REENTRY_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accKind == 2'd0 && curPriv == PRIV_M && !mprv && !mie |=> !fire); // R7
  AST_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !addrHit |=> !fire); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !fire); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !accValid && rstN && $past(rstN) |=> $stable(effMode)); // R10
endmodule

bind effpriv_trig_filter effpriv_trig_filter_chk u_chk (.*);

// File: tb/tb_effpriv_trig_filter.sv
module tb_effpriv_trig_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [1:0] curPriv = 2'd0;
  logic curVirt = 1'b0, mprv = 1'b0, mxr = 1'b0, mpv = 1'b0, spvp = 1'b0, mie = 1'b0;
  logic [1:0] mpp = 2'd0;
  logic [1:0] accKind = 2'd0;
  logic [4:0] modeEn = 5'd0;
  logic addrHit = 1'b0;
  logic fire;
  logic [2:0] effMode;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  effpriv_trig_filter dut (.*);

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  logic [1:0] expPriv;
  logic expVirt;
  logic expFire;
  string tagMode, tagFire;

  task automatic model();
    int idx;
    logic excl, sup, en;
    tagMode = "R2";
    if (accKind != 2'd0) begin
      expPriv = spvp ? 2'd1 : 2'd0; expVirt = 1'b1; tagMode = "R3";
    end else if (mprv && curPriv == 2'd3) begin
      expPriv = mpp; expVirt = (mpp == 2'd3) ? 1'b0 : mpv; tagMode = "R6";
    end else begin
      expPriv = curPriv; expVirt = (curPriv == 2'd3) ? 1'b0 : curVirt;
    end
    if (expPriv == 2'd2) en = 1'b0;
    else begin
      idx = (expPriv == 2'd3) ? 2 : (expVirt ? 3 + int'(expPriv) : int'(expPriv));
      en = modeEn[idx];
    end
    excl = (accKind == 2'd3) || (mprv && mxr);
    sup = (expPriv == 2'd3) && !mie;
    expFire = addrHit && en && !excl && !sup;
    if (accKind == 2'd3) tagFire = "R4";
    else if (mprv && mxr) tagFire = "R5";
    else if (sup) tagFire = "R7";
    else tagFire = "R8";
  endtask

  task automatic apply_and_check();
    accValid = 1'b1;
    model();
    @(posedge clk); #1;
    check(tagMode, 32'(effMode), 32'({expVirt, expPriv}));
    check(tagFire, 32'(fire), 32'(expFire));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(fire), 32'd0);
    check("R1", 32'(effMode), 32'h3);
    rstN = 1'b1;
    @(negedge clk);
    for (int cp = 0; cp < 4; cp++) begin
      if (cp == 2) continue;
      for (int bits = 0; bits < 64; bits++) begin
        for (int mp = 0; mp < 4; mp++) begin
          if (mp == 2) continue;
          for (int k = 0; k < 4; k++) begin
            for (int en = 0; en < 32; en++) begin
              curPriv = 2'(cp);
              {curVirt, mprv, mxr, mpv, spvp, mie} = 6'(bits);
              mpp = 2'(mp); accKind = 2'(k); modeEn = 5'(en); addrHit = 1'b1;
              apply_and_check();
            end
          end
        end
      end
    end
    // R8: no hit never fires, even with all enables
    modeEn = 5'h1f; addrHit = 1'b0; mprv = 1'b0; mxr = 1'b0; accKind = 2'd0; mie = 1'b1;
    for (int cp = 0; cp < 4; cp++) begin
      curPriv = 2'(cp); curVirt = 1'b1;
      apply_and_check();
    end
    // R8: reserved privilege code selects no enable
    addrHit = 1'b1; curPriv = 2'd2; curVirt = 1'b0;
    apply_and_check();
    // R9 / R10: idle cycle keeps mode, drops fire
    curPriv = 2'd1; curVirt = 1'b1; accKind = 2'd0; mprv = 1'b0;
    apply_and_check();
    check("R9", 32'(expFire), 32'd1);
    accValid = 1'b0; curPriv = 2'd0; curVirt = 1'b0;
    @(posedge clk); #1;
    check("R9", 32'(fire), 32'd0);
    check("R10", 32'(effMode), 32'h5);
    @(posedge clk); #1;
    check("R10", 32'(effMode), 32'h5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule